// File: doc/BRIEF.md
# Big-Endian Load/Store Data Aligner

This block sits between a processor's load/store path and a data memory that is 32 bits wide and addressed in words. Each request carries a byte address, an access size, a signed/unsigned flag and, for stores, the data to write. The aligner turns the byte address into a word address for the memory. For a store, it moves the low byte or low halfword of the store data onto the correct byte lanes and raises only the byte write enables that belong to the access.

Lanes are numbered big-endian: the byte at the lowest address of a word sits in the most significant eight bits. A load request is passed to the memory at once. The memory answers on the next clock edge, and the aligner keeps the offset, size and signedness of the request in a single register stage. One clock after the request, it picks the addressed byte or halfword out of the returned word and extends it to 32 bits, either with copies of the sign bit or with zeros.

A request whose address does not suit its size is flagged as misaligned in the same cycle. Such a request is not split into two accesses. It writes nothing and returns no load data.

Top module: `be_ls_aligner`

## Requirements
- R1: `mem_addr` equals `req_addr` with its two lowest bits forced to zero, in the same cycle as the request.
- R2: Lanes are big-endian. Byte offset 0 is data bits 31:24, offset 1 is 23:16, offset 2 is 15:8 and offset 3 is 7:0. A halfword at offset 0 is bits 31:16 and a halfword at offset 2 is bits 15:0. Write enable bit i covers data bits 8i+7:8i.
- R3: `ld_valid` is high exactly one clock after each aligned load request and low in every other cycle. `ld_data` is meaningful only while `ld_valid` is high.
- R4: When `req_signed` is 1, a byte or halfword load copies the top bit of the loaded value into all upper bits. For example, byte 0xFE returns 0xFFFFFFFE and byte 0x02 returns 0x00000002.
- R5: When `req_signed` is 0, a byte or halfword load fills all upper bits with zeros. For example, byte 0xFE returns 0x000000FE.
- R6: An aligned byte store (size code 2'b00) raises only write enable bit 3−offset. It drives `req_wdata[7:0]` on all four lanes of `mem_wdata`.
- R7: An aligned halfword store (size code 2'b01) raises enables 4'b1100 at offset 0 or 4'b0011 at offset 2. It drives `req_wdata[15:0]` on both halves of `mem_wdata`.
- R8: An aligned word store (size code 2'b10) raises all four enables and passes `req_wdata` through unchanged. An aligned word load returns the stored word unchanged, whatever the value of `req_signed`.
- R9: `misalign` is high in the request cycle in these cases: a halfword with address bit 0 set, a word with either low address bit set, or any request with the reserved size code 2'b11. A misaligned request drives all write enables low, keeps `mem_re` low, produces no `ld_valid` and leaves memory unchanged.
- R10: `mem_re` is high only during aligned load requests. All write enables are low during any load request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_signed | input | 1 | Sign-extend narrow loads when 1 |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| mem_addr | output | ADDR_W | Word-aligned address to memory |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 4 | Byte write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Word read from memory, one cycle after `mem_re` |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Current request is misaligned |

## Verification
A load result leaves the block in the same cycle that the next request, often a store, is presented. When both touch the same word, the memory must return the value from before the store, and the store's enables must not disturb the data path of the pending load. The bench sets this up by issuing a load and then, in the very next cycle, a store to the same word. The scoreboard must still see the old value, and a later readback must show the new bytes in their big-endian lanes.

// File: rtl/be_ls_aligner.sv
module be_ls_aligner #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic [3:0]        mem_we,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              ld_valid,
  output logic [31:0]       ld_data,
  output logic              misalign
);
  localparam logic [1:0] SZ_B = 2'b00;
  localparam logic [1:0] SZ_H = 2'b01;
  localparam logic [1:0] SZ_W = 2'b10;

  logic [1:0]  off;
  logic        bad;
  logic        go;
  logic [3:0]  we_lanes;
  logic [31:0] wd_lanes;

  assign off = req_addr[1:0];

  always_comb begin
    unique case (req_size)
      SZ_B:    bad = 1'b0;
      SZ_H:    bad = off[0];
      SZ_W:    bad = |off;
      default: bad = 1'b1;
    endcase
  end

  assign misalign = req_valid & bad;
  assign go       = req_valid & ~bad;
  assign mem_addr = {req_addr[ADDR_W-1:2], 2'b00};
  assign mem_re   = go & ~req_write;

  always_comb begin
    we_lanes = 4'h0;
    wd_lanes = req_wdata;
    unique case (req_size)
      SZ_B: begin
        wd_lanes = {4{req_wdata[7:0]}};
        we_lanes = 4'b1000 >> off;
      end
      SZ_H: begin
        wd_lanes = {2{req_wdata[15:0]}};
        we_lanes = off[1] ? 4'b0011 : 4'b1100;
      end
      SZ_W:    we_lanes = 4'hF;
      default: we_lanes = 4'h0;
    endcase
  end

  assign mem_we    = (go & req_write) ? we_lanes : 4'h0;
  assign mem_wdata = wd_lanes;

  logic       q_valid;
  logic [1:0] q_off;
  logic [1:0] q_size;
  logic       q_signed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_off    <= 2'b00;
      q_size   <= SZ_W;
      q_signed <= 1'b0;
    end else begin
      q_valid <= mem_re;
      if (mem_re) begin
        q_off    <= off;
        q_size   <= req_size;
        q_signed <= req_signed;
      end
    end
  end

  logic [31:0] shifted;
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  assign shifted = mem_rdata << {q_off, 3'b000};
  assign sel_b   = shifted[31:24];
  assign sel_h   = shifted[31:16];

  always_comb begin
    unique case (q_size)
      SZ_B:    ld_data = {{24{q_signed & sel_b[7]}}, sel_b};
      SZ_H:    ld_data = {{16{q_signed & sel_h[15]}}, sel_h};
      default: ld_data = mem_rdata;
    endcase
  end

  assign ld_valid = q_valid;
endmodule

// File: rtl/be_ls_aligner_chk.sv
module be_ls_aligner_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic              req_signed,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        mem_we,
  input logic              mem_re,
  input logic              ld_valid,
  input logic [31:0]       ld_data,
  input logic              misalign
);
  logic ld_req;
  assign ld_req = req_valid & ~req_write & ~misalign;

  p_misalign_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_we == 4'h0 && !mem_re));

  p_ld_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |=> ld_valid);

  p_ld_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_req |=> !ld_valid);

  p_byte_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size == 2'b00) |-> $countones(mem_we) == 1);

  p_half_two_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !misalign && req_size == 2'b01) |-> $countones(mem_we) == 2);

  p_word_all_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !misalign && req_size == 2'b10) |-> mem_we == 4'hF);

  p_load_no_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> mem_we == 4'h0);

  p_zero_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && req_size == 2'b00 && !req_signed) |=> ld_data[31:8] == 24'h0);

  p_sign_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && req_size == 2'b00 && req_signed) |=> ld_data[31:8] == {24{ld_data[7]}});

  p_reserved_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'b11) |-> misalign);
endmodule

bind be_ls_aligner be_ls_aligner_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
  .mem_we(mem_we), .mem_re(mem_re), .ld_valid(ld_valid), .ld_data(ld_data),
  .misalign(misalign)
);

// File: tb/test_be_ls_aligner.sv
`timescale 1ns/1ps
module test_be_ls_aligner;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
  logic [1:0]    req_size = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_re;
  logic [3:0]    mem_we;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata;
  logic          ld_valid, misalign;
  logic [31:0]   ld_data;

  always #5 clk = ~clk;

  be_ls_aligner #(.ADDR_W(AW)) i_be_ls_aligner (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .misalign(misalign)
  );

  logic [31:0] mem [16];
  logic [7:0]  shadow [64];

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      if (mem_we[i]) mem[mem_addr[5:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
    if (mem_re) mem_rdata <= mem[mem_addr[5:2]];
  end

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_load(input int a, input logic [1:0] sz, input logic sg);
    logic [31:0] v;
    case (sz)
      2'b00: v = {{24{sg & shadow[a][7]}}, shadow[a]};
      2'b01: v = {{16{sg & shadow[a][7]}}, shadow[a], shadow[a+1]};
      default: v = {shadow[a], shadow[a+1], shadow[a+2], shadow[a+3]};
    endcase
    return v;
  endfunction

  task automatic req(input logic wr, input logic [1:0] sz, input logic sg,
                     input int a, input logic [31:0] wd);
    logic bad;
    logic [3:0] we;
    logic [31:0] wdx;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_signed = sg;
    req_addr = AW'(a); req_wdata = wd;
    #1;
    bad = (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
    check("R9 misalign", {31'b0, misalign}, {31'b0, bad});
    check("R1 mem_addr", mem_addr, AW'(a & ~3));
    if (bad) begin
      check("R9 no enables", {28'b0, mem_we}, 32'h0);
      check("R9 no read", {31'b0, mem_re}, 32'h0);
    end else if (wr) begin
      case (sz)
        2'b00: begin we = 4'b1000 >> a[1:0]; wdx = {4{wd[7:0]}}; end
        2'b01: begin we = a[1] ? 4'b0011 : 4'b1100; wdx = {2{wd[15:0]}}; end
        default: begin we = 4'hF; wdx = wd; end
      endcase
      check(sz == 2'b00 ? "R6 enables" : sz == 2'b01 ? "R7 enables" : "R8 enables",
            {28'b0, mem_we}, {28'b0, we});
      check(sz == 2'b00 ? "R6 lanes" : sz == 2'b01 ? "R7 lanes" : "R8 lanes", mem_wdata, wdx);
      for (int i = 0; i < 4; i++)
        if (we[3-i]) shadow[(a & ~3) + i] = wdx[31-8*i -: 8];
    end else begin
      check("R10 read strobe", {31'b0, mem_re}, 32'h1);
      check("R10 no enables on load", {28'b0, mem_we}, 32'h0);
      exp_q.push_back(exp_load(a, sz, sg));
      tag_q.push_back(sz == 2'b10 ? "R8 word load" : sg ? "R2,R4 signed load" : "R2,R5 unsigned load");
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      #1;
      check("R10 idle read strobe", {31'b0, mem_re}, 32'h0);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && ld_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R3: actual ld_valid 1 expected 0");
      end else begin
        string t;
        logic [31:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, ld_data, e);
      end
    end
  end

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int k = 0; k < 64; k++) shadow[k] = 8'((k * 37 + 128) & 255);
    for (int w = 0; w < 16; w++)
      mem[w] = {shadow[4*w], shadow[4*w+1], shadow[4*w+2], shadow[4*w+3]};
    mem_rdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R3 reset ld_valid", {31'b0, ld_valid}, 32'h0);
    check("R9 reset misalign", {31'b0, misalign}, 32'h0);
    check("R10 reset enables", {28'b0, mem_we}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // R2 lane order, R4 and R5 extension on the initial pattern
    for (int o = 0; o < 4; o++) begin
      req(1'b0, 2'b00, 1'b1, 8 + o, 0);
      req(1'b0, 2'b00, 1'b0, 8 + o, 0);
    end
    req(1'b0, 2'b01, 1'b1, 12, 0);
    req(1'b0, 2'b01, 1'b0, 14, 0);
    req(1'b0, 2'b10, 1'b1, 16, 0);

    // R4/R5 with 0xFE and 0x02
    req(1'b1, 2'b00, 1'b0, 21, 32'hAAAA_AAFE);
    req(1'b1, 2'b00, 1'b0, 22, 32'h5555_5502);
    req(1'b0, 2'b00, 1'b1, 21, 0);
    req(1'b0, 2'b00, 1'b0, 21, 0);
    req(1'b0, 2'b00, 1'b1, 22, 0);
    req(1'b0, 2'b01, 1'b1, 20, 0);

    // R7 halfword stores at both offsets, R8 word store
    req(1'b1, 2'b01, 1'b0, 24, 32'h1234_8001);
    req(1'b1, 2'b01, 1'b0, 26, 32'hFFFF_7FFE);
    req(1'b0, 2'b10, 1'b0, 24, 0);
    req(1'b0, 2'b01, 1'b1, 24, 0);
    req(1'b0, 2'b01, 1'b0, 24, 0);
    req(1'b1, 2'b10, 1'b1, 28, 32'hCAFE_F00D);
    req(1'b0, 2'b10, 1'b1, 28, 0);
    idle(1);

    // R9 misaligned and reserved-size requests leave memory untouched
    req(1'b1, 2'b01, 1'b0, 33, 32'h0000_BEEF);
    req(1'b1, 2'b10, 1'b0, 34, 32'hDEAD_BEEF);
    req(1'b1, 2'b10, 1'b0, 35, 32'hDEAD_BEEF);
    req(1'b1, 2'b11, 1'b0, 32, 32'hDEAD_BEEF);
    req(1'b0, 2'b10, 1'b0, 33, 0);
    req(1'b0, 2'b01, 1'b1, 35, 0);
    req(1'b0, 2'b11, 1'b0, 36, 0);
    req(1'b0, 2'b10, 1'b0, 32, 0);

    // load then store to the same word in the next cycle
    req(1'b0, 2'b10, 1'b0, 40, 0);
    req(1'b1, 2'b00, 1'b0, 41, 32'h0000_0099);
    req(1'b0, 2'b10, 1'b0, 40, 0);
    req(1'b1, 2'b01, 1'b0, 42, 32'h0000_1357);
    req(1'b0, 2'b10, 1'b0, 40, 0);
    req(1'b0, 2'b00, 1'b0, 43, 0);
    idle(3);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R3: actual %0d pending loads expected 0", exp_q.size());
    end
    finish_up();
  end
endmodule